// File: doc/BRIEF.md
# Edge Timestamp Capture Unit

This block records the moment an external signal changes. The raw capture input first passes through a synchroniser. An optional filter can then suppress short glitches. On the chosen edge polarity, the value of a free-running counter, which is supplied from outside the block, is copied into a capture register. The same edge raises a sticky flag, and an interrupt request follows the flag when interrupts are enabled.

Software or a neighbouring timer controls the unit through plain level inputs: filter on or off, edge polarity, interrupt enable, a one-cycle flag-clear strobe, and a capture-disable level. The disable level is asserted whenever the timer uses the capture register as its period limit. In that mode the pin is ignored. The unit has no counter, prescaler or bus interface of its own.

Top module: `capture_timestamp`

## Requirements
- R1: After reset, `capture_val` is 0, `cap_flag` is 0 and `cap_irq` is 0.
- R2: With the filter off, a pin change launched before clock edge 1 is captured on clock edge 3. `capture_val` then takes the `count_in` value sampled at that edge, and `cap_flag` is 1 after that edge.
- R3: `edge_rise` = 1 captures on a low-to-high transition of the pin, and `edge_rise` = 0 captures on a high-to-low transition. The opposite transition is ignored.
- R4: With `filt_en` = 1, a pin level that lasts fewer than four consecutive clock samples produces no capture. A level lasting four or more samples passes the filter.
- R5: With `filt_en` = 1, every capture happens exactly four clock cycles later than it would with the filter off.
- R6: `cap_flag` stays 1 until `flag_clr` is 1 in a cycle with no capture. It is then 0 after that edge.
- R7: When a capture and `flag_clr` occur in the same cycle, `cap_flag` remains 1.
- R8: `cap_irq` is 1 exactly when `cap_flag` is 1 and `irq_en` is 1.
- R9: While `cap_off` is 1, pin activity neither changes `capture_val` nor sets `cap_flag`.
- R10: Changing `edge_rise` while the pin is steady causes no capture.
- R11: `capture_val` holds its value in every cycle without a capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cap_pin | input | 1 | Raw asynchronous capture input |
| count_in | input | CNT_W | Free-running counter value to timestamp |
| filt_en | input | 1 | 1 enables the four-sample glitch filter |
| edge_rise | input | 1 | 1 = rising-edge trigger, 0 = falling-edge trigger |
| irq_en | input | 1 | Interrupt request enable |
| flag_clr | input | 1 | One-cycle strobe that clears the capture flag |
| cap_off | input | 1 | 1 disconnects the pin (register used as counter limit) |
| capture_val | output | CNT_W | Last captured counter value |
| cap_flag | output | 1 | Sticky capture flag |
| cap_irq | output | 1 | Interrupt request |

## Verification
The assertions check the following on every cycle:
- the register load from the counter on each internal capture event;
- that the register holds between events;
- that the flag stays set, and that a capture wins over a clear;
- that the interrupt is gated by its enable;
- that the register is frozen while capture is disabled.

The exact latency through the synchroniser and the filter can only be shown by the bench scenarios. The same holds for the rejection of glitches shorter than four samples and the choice of edge polarity. The bench sweeps pulse lengths against both filter settings and both polarities, and computes each expected timestamp from the cycle in which the pin changed.

// File: rtl/capture_timestamp_pkg.sv
// Shared types for the edge timestamp capture unit.
// Assumes nothing beyond IEEE 1800-2017 packages.
package capture_timestamp_pkg;

    // Edge polarity selected by the edge_rise control level.
    typedef enum logic {
        POL_FALL = 1'b0,
        POL_RISE = 1'b1
    } edge_pol_e;

    // Minimum number of synchroniser stages for metastability protection.
    localparam int unsigned MIN_SYNC = 2;

endpackage

// File: rtl/cap_sync.sv
// Multi-stage synchroniser for the asynchronous capture pin.
// Assumes STAGES >= 2; output lags the pin by STAGES clock edges.
module cap_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    // Shift the raw level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], din};
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/cap_filter.sv
// Glitch filter: the output moves to a new level only after LEN
// consecutive samples of the input agree. Adds LEN cycles of delay.
// Assumes LEN >= 2 and a synchronised input.
module cap_filter #(
    parameter int unsigned LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int unsigned HW = LEN - 1;

    logic [HW-1:0] hist_q;
    logic [LEN-1:0] window;
    logic          all_hi;
    logic          all_lo;
    logic          level_q;

    generate
        if (HW == 1) begin : g_one
            // Keep the single previous sample.
            always_ff @(posedge clk) begin
                if (!rst_n) hist_q <= '0;
                else        hist_q <= din;
            end
        end else begin : g_many
            // Keep the last HW samples in a shift register.
            always_ff @(posedge clk) begin
                if (!rst_n) hist_q <= '0;
                else        hist_q <= {hist_q[HW-2:0], din};
            end
        end
    endgenerate

    // Detect a window of identical samples including the current one.
    always_comb begin
        window = {hist_q, din};
        all_hi = &window;
        all_lo = ~|window;
    end

    // Commit the level once the window is unanimous.
    always_ff @(posedge clk) begin
        if (!rst_n)      level_q <= 1'b0;
        else if (all_hi) level_q <= 1'b1;
        else if (all_lo) level_q <= 1'b0;
    end

    assign dout = level_q;
endmodule

// File: rtl/cap_edge.sv
// Edge detector: compares the chosen level with its previous sample and
// reports a one-cycle event for the selected polarity. Event is gated off
// while the pin is disconnected. Polarity changes alone never fire.
module cap_edge
    import capture_timestamp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      level,
    input  edge_pol_e pol,
    input  logic      disable_in,
    output logic      event_out
);
    logic prev_q;
    logic rise;
    logic fall;

    // Remember the level seen in the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level;
    end

    // Pick the transition of the selected polarity.
    always_comb begin
        rise      = level & ~prev_q;
        fall      = ~level & prev_q;
        event_out = 1'b0;
        if (!disable_in) begin
            event_out = (pol == POL_RISE) ? rise : fall;
        end
    end
endmodule

// File: rtl/cap_store.sv
// Capture register and sticky flag. A capture wins over a clear in the
// same cycle. The interrupt request follows the flag when enabled.
module cap_store #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_evt,
    input  logic [CNT_W-1:0] count_in,
    input  logic             clr,
    input  logic             irq_en,
    output logic [CNT_W-1:0] value,
    output logic             flag,
    output logic             irq
);
    logic [CNT_W-1:0] value_q;
    logic             flag_q;

    // Load the timestamp on an event.
    always_ff @(posedge clk) begin
        if (!rst_n)       value_q <= '0;
        else if (cap_evt) value_q <= count_in;
    end

    // Set on capture, clear on strobe, capture has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (cap_evt) flag_q <= 1'b1;
        else if (clr)     flag_q <= 1'b0;
    end

    assign value = value_q;
    assign flag  = flag_q;
    assign irq   = flag_q & irq_en;
endmodule

// File: rtl/capture_timestamp.sv
// Top of the edge timestamp capture unit: synchroniser, optional glitch
// filter, polarity edge detector and capture storage.
// Assumes count_in is synchronous to clk.
module capture_timestamp
    import capture_timestamp_pkg::*;
#(
    parameter int unsigned CNT_W    = 16,
    parameter int unsigned SYNC_N   = 2,
    parameter int unsigned FILT_LEN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_pin,
    input  logic [CNT_W-1:0] count_in,
    input  logic             filt_en,
    input  logic             edge_rise,
    input  logic             irq_en,
    input  logic             flag_clr,
    input  logic             cap_off,
    output logic [CNT_W-1:0] capture_val,
    output logic             cap_flag,
    output logic             cap_irq
);
    localparam int unsigned SYNC_USE = (SYNC_N < MIN_SYNC) ? MIN_SYNC : SYNC_N;

    logic      pin_sync;
    logic      pin_filt;
    logic      pin_level;
    logic      cap_evt;
    edge_pol_e pol;

    cap_sync #(.STAGES(SYNC_USE)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (cap_pin),
        .dout (pin_sync)
    );

    cap_filter #(.LEN(FILT_LEN)) u_filt (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_sync),
        .dout (pin_filt)
    );

    // Select filtered or direct level and decode the polarity control.
    always_comb begin
        pin_level = filt_en ? pin_filt : pin_sync;
        pol       = edge_rise ? POL_RISE : POL_FALL;
    end

    cap_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .level     (pin_level),
        .pol       (pol),
        .disable_in(cap_off),
        .event_out (cap_evt)
    );

    cap_store #(.CNT_W(CNT_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_evt (cap_evt),
        .count_in(count_in),
        .clr     (flag_clr),
        .irq_en  (irq_en),
        .value   (capture_val),
        .flag    (cap_flag),
        .irq     (cap_irq)
    );
endmodule

// File: rtl/capture_timestamp_chk.sv
// Checker for the edge timestamp capture unit, bound to the top module.
// Observes ports plus the internal capture event from the edge detector.
module capture_timestamp_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] count_in,
    input logic [CNT_W-1:0] capture_val,
    input logic             cap_flag,
    input logic             cap_irq,
    input logic             irq_en,
    input logic             flag_clr,
    input logic             cap_off,
    input logic             cap_evt
);
    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> capture_val == $past(count_in));

    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cap_flag && !flag_clr |=> cap_flag);

    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr && !cap_evt |=> !cap_flag);

    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> cap_flag);

    p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cap_irq |-> (irq_en && cap_flag));

    p_frozen_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cap_off |=> $stable(capture_val));

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_evt |=> $stable(capture_val));
endmodule

bind capture_timestamp capture_timestamp_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .count_in   (count_in),
    .capture_val(capture_val),
    .cap_flag   (cap_flag),
    .cap_irq    (cap_irq),
    .irq_en     (irq_en),
    .flag_clr   (flag_clr),
    .cap_off    (cap_off),
    .cap_evt    (cap_evt)
);

// File: tb/capture_timestamp_test.sv
module capture_timestamp_test;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cap_pin;
    logic [CW-1:0] count_in;
    logic          filt_en;
    logic          edge_rise;
    logic          irq_en;
    logic          flag_clr;
    logic          cap_off;
    logic [CW-1:0] capture_val;
    logic          cap_flag;
    logic          cap_irq;

    int checks = 0;
    int errors = 0;
    int cnt_v  = 0;

    capture_timestamp #(.CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .cap_pin(cap_pin), .count_in(count_in),
        .filt_en(filt_en), .edge_rise(edge_rise), .irq_en(irq_en),
        .flag_clr(flag_clr), .cap_off(cap_off), .capture_val(capture_val),
        .cap_flag(cap_flag), .cap_irq(cap_irq)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Advance to the next falling edge and move the counter.
    task automatic tick();
        @(negedge clk);
        cnt_v    = (cnt_v + 1) % (1 << CW);
        count_in = cnt_v[CW-1:0];
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1;
        tick();
        flag_clr = 1'b0;
    endtask

    // One pulse of length len from a low idle level; checks R2..R5, R8, R11.
    task automatic pulse(input bit filt, input bit es, input int len, input bit ie);
        int c0;
        int c1;
        int d;
        bit pass;
        logic [CW-1:0] prev;
        logic [CW-1:0] expv;
        filt_en   = filt;
        edge_rise = es;
        irq_en    = ie;
        repeat (10) tick();
        clear_flag();
        tick();
        prev    = capture_val;
        cap_pin = 1'b1;
        c0      = cnt_v;
        repeat (len) tick();
        cap_pin = 1'b0;
        c1      = cnt_v;
        repeat (12) tick();
        pass = !filt || (len >= 4);
        d    = filt ? 6 : 2;
        expv = pass ? CW'(es ? c0 + d : c1 + d) : prev;
        check(filt ? "R4/R5 filtered capture value" : "R2/R3 direct capture value",
              32'(capture_val), 32'(expv));
        check("R4 flag after pulse", 32'(cap_flag), 32'(pass));
        check("R8 irq follows flag and enable", 32'(cap_irq), 32'(pass && ie));
    endtask

    // Exact cycle of the flag set after a rising pin change.
    task automatic latency(input bit filt);
        int d;
        filt_en   = filt;
        edge_rise = 1'b1;
        cap_pin   = 1'b0;
        repeat (12) tick();
        clear_flag();
        tick();
        cap_pin = 1'b1;
        d = filt ? 7 : 3;
        for (int k = 1; k <= d; k++) begin
            tick();
            if (k == d - 1) check(filt ? "R5 flag not early" : "R2 flag not early",
                                  32'(cap_flag), 32'd0);
            if (k == d)     check(filt ? "R5 flag at cycle" : "R2 flag at cycle",
                                  32'(cap_flag), 32'd1);
        end
        cap_pin = 1'b0;
        repeat (12) tick();
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [CW-1:0] held;
        int c0;
        rst_n = 1'b0; cap_pin = 1'b0; count_in = '0; filt_en = 1'b0;
        edge_rise = 1'b0; irq_en = 1'b0; flag_clr = 1'b0; cap_off = 1'b0;
        repeat (3) tick();
        check("R1 reset capture", 32'(capture_val), 32'd0);
        check("R1 reset flag", 32'(cap_flag), 32'd0);
        check("R1 reset irq", 32'(cap_irq), 32'd0);
        rst_n = 1'b1;
        tick();

        // Sweep filter, polarity and pulse length.
        for (int f = 0; f < 2; f++)
            for (int e = 0; e < 2; e++)
                for (int l = 1; l <= 6; l++)
                    pulse(f[0], e[0], l, l[0]);

        latency(1'b0);
        latency(1'b1);

        // R6: flag stays set without clear, then clears.
        pulse(1'b0, 1'b1, 3, 1'b1);
        repeat (5) tick();
        check("R6 flag sticky", 32'(cap_flag), 32'd1);
        clear_flag();
        check("R6 flag cleared", 32'(cap_flag), 32'd0);
        check("R8 irq drops with flag", 32'(cap_irq), 32'd0);

        // R7: clear strobe in the capture cycle loses.
        filt_en = 1'b0; edge_rise = 1'b1;
        repeat (4) tick();
        cap_pin = 1'b1;
        c0 = cnt_v;
        tick(); tick();
        flag_clr = 1'b1;
        tick();
        flag_clr = 1'b0;
        check("R7 capture beats clear", 32'(cap_flag), 32'd1);
        check("R7 value on collision", 32'(capture_val), 32'(CW'(c0 + 2)));

        // R10: polarity toggles with a steady high pin.
        repeat (6) tick();
        clear_flag();
        held = capture_val;
        for (int t = 0; t < 6; t++) begin
            edge_rise = ~edge_rise;
            tick();
        end
        check("R10 no capture on polarity change", 32'(cap_flag), 32'd0);
        check("R11 value held", 32'(capture_val), 32'(held));

        // R9: pin disconnected.
        cap_pin = 1'b0;
        edge_rise = 1'b1;
        repeat (6) tick();
        clear_flag();
        held = capture_val;
        cap_off = 1'b1;
        for (int t = 0; t < 4; t++) begin
            cap_pin = ~cap_pin;
            repeat (5) tick();
        end
        check("R9 flag stays clear when off", 32'(cap_flag), 32'd0);
        check("R9 value frozen when off", 32'(capture_val), 32'(held));
        cap_off = 1'b0;
        repeat (4) tick();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule